// File: doc/BRIEF.md
# Receive Pause Timer

This block is a 16-bit down-counting timer that marks a gap in an incoming serial character stream. Software loads a reload value one byte at a time and can read the live count one byte at a time. Two read-only addresses act as commands: reading one loads the reload value and starts the count, and reading the other halts it. When a running count passes zero, a ready flag is raised and the count reloads from the reload value.

With pause mode selected, every strobe from the receiver saying a character has arrived reloads and restarts the count and clears the ready flag. The timer therefore only fires once the line has been quiet for the programmed number of count-enable ticks. Clearing the flag also withdraws an interrupt that is still pending. An interrupt handler that reaches the status register after the stream has resumed can find every bit at zero.

The ready flag takes one position in an 8-bit interrupt status byte. The other seven positions carry status from neighbouring logic. A mask register selects which positions drive the interrupt line.

Top module: `rx_timeout_timer`

## Requirements
- R1: After reset the count is stopped at zero, the reload value is zero, the ready flag is clear, the mask is zero and `irq` is low.
- R2: A bus write to address 0x6 sets the reload value's upper byte and a write to 0x7 sets its lower byte. Neither write changes the live count.
- R3: A bus read of address 0x6 returns the live count's upper byte and a read of 0x7 returns its lower byte, as they stand before that cycle's clock edge.
- R4: A bus read of address 0xE loads the reload value into the count and starts it. While running, the count drops by one on each clock with `cnt_en` high. While stopped, it holds.
- R5: A clock with `cnt_en` high while running at a count of zero sets the ready flag and reloads the count from the reload value. The flag then stays set until R6 or R7 clears it.
- R6: A bus read of address 0xF stops the count, keeps its value and clears the ready flag. It takes priority over a receiver strobe in the same cycle.
- R7: With `tmo_mode` high, an `rx_char` pulse reloads the count, starts it and clears the ready flag. With `tmo_mode` low, `rx_char` has no effect.
- R8: A bus read of address 0x5 returns the status byte. Bit 3 is the ready flag, bits 2..0 are `aux_status[2:0]`, and bits 7..4 are `aux_status[6:3]`. After R7 clears the flag with no other source active, the byte reads 0x00.
- R9: A bus write to address 0x5 sets the mask. `irq` is high exactly when some status bit and its mask bit are both 1.
- R10: A bus read of any address other than 0x5, 0x6 or 0x7 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| cnt_en | input | 1 | Count-enable tick |
| tmo_mode | input | 1 | Selects pause mode, in which receiver strobes restart the count |
| rx_char | input | 1 | One-cycle strobe per received character |
| aux_status | input | 7 | Status bits from neighbouring logic |
| irq | output | 1 | Masked interrupt request |

## Verification
A wrong count shows up on the very next byte read of 0x6 or 0x7. The bench reads the count after each burst of ticks and after each restart, so a missed decrement or a stale reload appears within a few cycles. A ready flag that is not set, or not withdrawn, shows in bit 3 of the status read and on `irq` in the cycle after the edge that should have changed it. A bad priority between stop, start and receiver restart leaves a count that keeps moving, or holds when it should move, and this is visible on the next count read.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int RDY_BIT = 3;

  localparam logic [ADDR_W-1:0] A_STAT  = 4'h5;
  localparam logic [ADDR_W-1:0] A_CNTHI = 4'h6;
  localparam logic [ADDR_W-1:0] A_CNTLO = 4'h7;
  localparam logic [ADDR_W-1:0] A_START = 4'hE;
  localparam logic [ADDR_W-1:0] A_STOP  = 4'hF;

  typedef struct packed {
    logic start;
    logic stop;
    logic wr_hi;
    logic wr_lo;
    logic wr_mask;
  } tmo_cmd_t;
endpackage

// File: rtl/tmo_decode.sv
module tmo_decode
  import tmo_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output tmo_cmd_t          cmd
);
  always_comb begin
    cmd         = '0;
    cmd.start   = rd && (addr == A_START);
    cmd.stop    = rd && (addr == A_STOP);
    cmd.wr_hi   = wr && (addr == A_CNTHI);
    cmd.wr_lo   = wr && (addr == A_CNTLO);
    cmd.wr_mask = wr && (addr == A_STAT);
  end
endmodule

// File: rtl/tmo_config.sv
module tmo_config
  import tmo_pkg::*;
#(
  parameter int BYTE_W = DATA_W,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmo_cmd_t          cmd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  preset,
  output logic [BYTE_W-1:0] mask
);
  logic [CNT_W-1:0]  preset_n;
  logic [BYTE_W-1:0] mask_n;

  always_comb begin
    preset_n = preset;
    mask_n   = mask;
    if (cmd.wr_hi)   preset_n[CNT_W-1:BYTE_W] = wdata;
    if (cmd.wr_lo)   preset_n[BYTE_W-1:0]     = wdata;
    if (cmd.wr_mask) mask_n                   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset <= '0;
      mask   <= '0;
    end else begin
      preset <= preset_n;
      mask   <= mask_n;
    end
  end
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter
  import tmo_pkg::*;
#(
  parameter int CNT_W = 2 * DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmo_cmd_t         cmd,
  input  logic [CNT_W-1:0] preset,
  input  logic             cnt_en,
  input  logic             tmo_mode,
  input  logic             rx_char,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             rdy
);
  logic [CNT_W-1:0] cnt_n;
  logic             run_n;
  logic             rdy_n;
  logic             rx_restart;
  logic             at_zero;

  assign rx_restart = tmo_mode && rx_char;
  assign at_zero    = (cnt == '0);

  always_comb begin
    cnt_n = cnt;
    run_n = run;
    rdy_n = rdy;
    if (cmd.stop) begin
      run_n = 1'b0;
      rdy_n = 1'b0;
    end else if (cmd.start || rx_restart) begin
      cnt_n = preset;
      run_n = 1'b1;
      if (rx_restart) rdy_n = 1'b0;
    end else if (run && cnt_en) begin
      if (at_zero) begin
        cnt_n = preset;
        rdy_n = 1'b1;
      end else begin
        cnt_n = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
      rdy <= 1'b0;
    end else begin
      cnt <= cnt_n;
      run <= run_n;
      rdy <= rdy_n;
    end
  end
endmodule

// File: rtl/tmo_status.sv
module tmo_status
  import tmo_pkg::*;
#(
  parameter int BYTE_W = DATA_W,
  parameter int RBIT   = RDY_BIT,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-2:0] aux,
  input  logic              rdy,
  input  logic [BYTE_W-1:0] mask,
  input  logic [CNT_W-1:0]  cnt,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  logic [BYTE_W-1:0] isr;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_isr
    if (i < RBIT) begin : g_low
      assign isr[i] = aux[i];
    end else if (i == RBIT) begin : g_rdy
      assign isr[i] = rdy;
    end else begin : g_high
      assign isr[i] = aux[i-1];
    end
  end

  assign irq = |(isr & mask);

  always_comb begin
    unique case (addr)
      A_STAT:  rdata = isr;
      A_CNTHI: rdata = cnt[CNT_W-1:BYTE_W];
      A_CNTLO: rdata = cnt[BYTE_W-1:0];
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/rx_timeout_timer.sv
module rx_timeout_timer
  import tmo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cnt_en,
  input  logic              tmo_mode,
  input  logic              rx_char,
  input  logic [DATA_W-2:0] aux_status,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  tmo_cmd_t          cmd;
  logic [CNT_W-1:0]  preset;
  logic [DATA_W-1:0] mask;
  logic [CNT_W-1:0]  cnt;
  logic              run;
  logic              rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  tmo_decode u_dec (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .cmd  (cmd)
  );

  tmo_config #(.BYTE_W(DATA_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cmd    (cmd),
    .wdata  (bus_wdata),
    .preset (preset),
    .mask   (mask)
  );

  tmo_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd      (cmd),
    .preset   (preset),
    .cnt_en   (cnt_en),
    .tmo_mode (tmo_mode),
    .rx_char  (rx_char),
    .cnt      (cnt),
    .run      (run),
    .rdy      (rdy)
  );

  tmo_status #(.BYTE_W(DATA_W), .RBIT(RDY_BIT)) u_stat (
    .addr  (bus_addr),
    .aux   (aux_status),
    .rdy   (rdy),
    .mask  (mask),
    .cnt   (cnt),
    .rdata (bus_rdata),
    .irq   (irq)
  );
endmodule

// File: rtl/rx_timeout_timer_chk.sv
module rx_timeout_timer_chk
  import tmo_pkg::*;
#(
  parameter int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_int_n,
  input tmo_cmd_t          cmd,
  input logic [CNT_W-1:0]  preset,
  input logic [DATA_W-1:0] mask,
  input logic [CNT_W-1:0]  cnt,
  input logic              run,
  input logic              rdy,
  input logic              cnt_en,
  input logic              tmo_mode,
  input logic              rx_char,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq
);
  logic rst_seen;
  logic quiet;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rst_seen <= 1'b0;
    else            rst_seen <= 1'b1;
  end

  assign quiet = !cmd.stop && !cmd.start && !(tmo_mode && rx_char);

  a_r7_rx_reload: assert property (@(posedge clk) disable iff (!rst_int_n || !rst_seen)
    (tmo_mode && rx_char && !cmd.stop) |=> (cnt == $past(preset) && !rdy && run));

  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_int_n || !rst_seen)
    cmd.stop |=> (!rdy && !run));

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_int_n || !rst_seen)
    (quiet && run && cnt_en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_int_n || !rst_seen)
    (quiet && !run) |=> $stable(cnt));

  a_r5_terminal: assert property (@(posedge clk) disable iff (!rst_int_n || !rst_seen)
    (quiet && run && cnt_en && cnt == '0) |=> (rdy && cnt == $past(preset)));

  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rdy && mask[RDY_BIT]) |-> irq);

  a_r8_stat_bit: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_rd && bus_addr == A_STAT) |-> (bus_rdata[RDY_BIT] == rdy));
endmodule

bind rx_timeout_timer rx_timeout_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .cmd       (cmd),
  .preset    (preset),
  .mask      (mask),
  .cnt       (cnt),
  .run       (run),
  .rdy       (rdy),
  .cnt_en    (cnt_en),
  .tmo_mode  (tmo_mode),
  .rx_char   (rx_char),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq)
);

// File: tb/rx_timeout_timer_tb.sv
module rx_timeout_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cnt_en = 1'b0;
  logic       tmo_mode = 1'b0;
  logic       rx_char = 1'b0;
  logic [6:0] aux_status = '0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_timeout_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_en(cnt_en), .tmo_mode(tmo_mode), .rx_char(rx_char),
    .aux_status(aux_status), .irq(irq)
  );

  localparam logic [3:0] K_WR = 4'd0, K_RD = 4'd1, K_TK = 4'd2,
                         K_RX = 4'd3, K_IQ = 4'd4, K_MD = 4'd5;
  localparam int NV = 38;
  // {kind, requirement, addr, data, expected}
  localparam logic [27:0] VEC [NV] = '{
    {K_WR, 4'd2,  4'h6, 8'h00, 8'h00},  // R2 reload upper
    {K_WR, 4'd2,  4'h7, 8'h03, 8'h00},  // R2 reload lower
    {K_RD, 4'd2,  4'h6, 8'h00, 8'h00},  // R2 live count untouched
    {K_RD, 4'd2,  4'h7, 8'h00, 8'h00},
    {K_RD, 4'd10, 4'hE, 8'h00, 8'h00},  // R10 start reads zero, R4 starts
    {K_RD, 4'd4,  4'h7, 8'h00, 8'h03},  // R4 loaded
    {K_TK, 4'd4,  4'h0, 8'd2,  8'h00},
    {K_RD, 4'd3,  4'h7, 8'h00, 8'h01},  // R3 lower byte
    {K_TK, 4'd4,  4'h0, 8'd1,  8'h00},
    {K_RD, 4'd5,  4'h5, 8'h00, 8'h00},  // R5 not yet
    {K_TK, 4'd5,  4'h0, 8'd1,  8'h00},
    {K_RD, 4'd5,  4'h5, 8'h00, 8'h08},  // R5 ready at bit 3
    {K_RD, 4'd5,  4'h7, 8'h00, 8'h03},  // R5 reloaded
    {K_IQ, 4'd9,  4'h0, 8'h00, 8'h00},  // R9 mask zero
    {K_WR, 4'd9,  4'h5, 8'h08, 8'h00},
    {K_IQ, 4'd9,  4'h0, 8'h00, 8'h01},  // R9 masked in
    {K_RX, 4'd7,  4'h0, 8'h00, 8'h00},  // R7 mode off
    {K_RD, 4'd7,  4'h5, 8'h00, 8'h08},
    {K_RD, 4'd7,  4'h7, 8'h00, 8'h03},
    {K_MD, 4'd7,  4'h0, 8'h01, 8'h00},
    {K_RX, 4'd7,  4'h0, 8'h00, 8'h00},  // R7 withdraw
    {K_RD, 4'd8,  4'h5, 8'h00, 8'h00},  // R8 reads 0x00
    {K_IQ, 4'd8,  4'h0, 8'h00, 8'h00},
    {K_TK, 4'd4,  4'h0, 8'd2,  8'h00},
    {K_RD, 4'd4,  4'h7, 8'h00, 8'h01},
    {K_RX, 4'd7,  4'h0, 8'h00, 8'h00},
    {K_RD, 4'd7,  4'h7, 8'h00, 8'h03},  // R7 restart
    {K_WR, 4'd2,  4'h6, 8'h01, 8'h00},
    {K_WR, 4'd2,  4'h7, 8'h00, 8'h00},
    {K_RD, 4'd2,  4'h7, 8'h00, 8'h03},  // R2 count unchanged by write
    {K_RX, 4'd7,  4'h0, 8'h00, 8'h00},
    {K_RD, 4'd3,  4'h6, 8'h00, 8'h01},  // R3 upper byte
    {K_TK, 4'd4,  4'h0, 8'd1,  8'h00},
    {K_RD, 4'd3,  4'h7, 8'h00, 8'hFF},  // R3 borrow
    {K_RD, 4'd6,  4'hF, 8'h00, 8'h00},  // R6 stop
    {K_TK, 4'd6,  4'h0, 8'd3,  8'h00},
    {K_RD, 4'd6,  4'h7, 8'h00, 8'hFF},  // R6 holds
    {K_MD, 4'd7,  4'h0, 8'h00, 8'h00}
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [7:0] exp, input int req);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #2 check(req, bus_rdata, exp);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic do_tick(input int n);
    @(negedge clk); cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic do_rx();
    @(negedge clk); rx_char = 1'b1;
    @(negedge clk); rx_char = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input int req);
    @(negedge clk);
    #2 check(req, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    do_rd(4'h6, 8'h00, 1);
    do_rd(4'h7, 8'h00, 1);
    do_rd(4'h5, 8'h00, 1);
    chk_irq(1'b0, 1);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] k, r, a;
      logic [7:0] d, e;
      {k, r, a, d, e} = VEC[i];
      case (k)
        K_WR: do_wr(a, d);
        K_RD: do_rd(a, e, int'(r));
        K_TK: do_tick(int'(d));
        K_RX: do_rx();
        K_IQ: chk_irq(e[0], int'(r));
        default: begin @(negedge clk); tmo_mode = d[0]; end
      endcase
    end

    // R5 and R6: reload value zero fires on first tick, stop clears flag
    do_wr(4'h6, 8'h00);
    do_wr(4'h7, 8'h00);
    do_rd(4'hE, 8'h00, 10);
    do_tick(1);
    do_rd(4'h5, 8'h08, 5);
    chk_irq(1'b1, 9);
    do_rd(4'hF, 8'h00, 6);
    do_rd(4'h5, 8'h00, 6);
    chk_irq(1'b0, 6);

    // R8 other sources placed around bit 3
    @(negedge clk); aux_status = 7'h7F;
    do_rd(4'h5, 8'hF7, 8);
    chk_irq(1'b0, 9);
    do_wr(4'h5, 8'h80);
    chk_irq(1'b1, 9);
    @(negedge clk); aux_status = 7'h00;
    chk_irq(1'b0, 9);
    do_rd(4'h3, 8'h00, 10);

    // R1 reset clears reload value and mask
    do_wr(4'h7, 8'h05);
    do_reset();
    do_rd(4'h5, 8'h00, 1);
    chk_irq(1'b0, 1);
    do_rd(4'hE, 8'h00, 1);
    do_rd(4'h7, 8'h00, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule